// File: doc/BRIEF.md
# PCI Initiator Transfer Sequencer

This block carries out the bus side of one PCI initiator transaction at a time. A requester hands over a start address, a bus command and a burst length. The block then drives the address phase, runs the data phases and reports how the transaction ended. It drives the active-low cycle-framing and initiator-ready strobes, and it samples the target's device-select, target-ready and stop strobes. Bus arbitration, parity and configuration cycles are handled elsewhere.

Write data is fetched by index. The block presents the number of the word it is about to send, and the requester places that word on `wr_data` in the same cycle. Read words come back one cycle after the edge that completed them. At the end of every transaction the block holds one turnaround cycle with both of its strobes released. In that cycle it raises `done_valid` together with a completion code, the number of words moved and a copy of the original request. The requester can reissue that copy unchanged after a retry.

The ending is sorted into five codes: 0 normal, 1 retry, 2 disconnect, 3 target abort, 4 master abort. A master abort is raised when no target claims the cycle within a fixed window of clocks after the address phase.

Top module: `pci_init_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `frame_n` and `irdy_n` are high, `ad_oe` and `done_valid` are low and `req_ready` is high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The next cycle is the address phase: `frame_n` low, `irdy_n` high, `ad_oe` high, `ad_out` equal to the address and `cbe_out` equal to the command.
- R3: After the address phase every cycle until termination is a data phase with `irdy_n` low. A command with bit 0 set is a write: `ad_oe` is high and `ad_out` carries `wr_data`, where `wr_idx` equals the number of words already transferred. Any other command is a read, with `ad_oe` low.
- R4: A word moves only on an edge where `trdy_n` and `devsel_n` are both low; any other data-phase clock is a wait state that leaves `wr_idx` unchanged. For reads, `rd_valid` is high in the following cycle with `rd_data` equal to the `ad_in` value sampled at that edge.
- R5: A burst moves `req_len + 1` words. `frame_n` is low in every data phase before the final word and high during the data phase of the final word.
- R6: If `devsel_n` is still high on the fifth clock edge after the address phase, the transaction ends as a master abort (code 4) with a count of 0. A claim on the fifth edge avoids the abort.
- R7: `stop_n` low together with `trdy_n` and `devsel_n` low ends the transaction as a disconnect (code 2). The word on that edge is counted.
- R8: `stop_n` low with `devsel_n` low and `trdy_n` high ends the transaction. It is a retry (code 1, count 0) if no word has moved, otherwise a disconnect (code 2) counting only the earlier words. After a retry, `done_addr`, `done_cmd` and `done_len` equal the original request.
- R9: `stop_n` low with `devsel_n` high after the target has claimed the cycle ends the transaction as a target abort (code 3), counting the words already moved.
- R10: A burst that finishes without termination reports code 0 with `done_count` equal to `req_len + 1`.
- R11: Each transaction ends with exactly one turnaround cycle where `frame_n` and `irdy_n` are high, `ad_oe` is low and `done_valid` is high. `req_ready` returns high in the cycle after it.
- R12: `req_ready` stays low from acceptance through the turnaround cycle, and `req_valid` has no effect during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | DATA_W | Start address |
| req_cmd | input | 4 | Bus command; bit 0 set means write |
| req_len | input | LEN_W | Burst length minus one, in words |
| wr_idx | output | LEN_W | Index of the write word wanted now |
| wr_data | input | DATA_W | Write word for `wr_idx` |
| rd_valid | output | 1 | Read word available |
| rd_data | output | DATA_W | Read word |
| done_valid | output | 1 | Completion report, one cycle |
| done_code | output | 3 | 0 normal, 1 retry, 2 disconnect, 3 target abort, 4 master abort |
| done_count | output | LEN_W+1 | Words transferred |
| done_addr | output | DATA_W | Address of the finished request |
| done_cmd | output | 4 | Command of the finished request |
| done_len | output | LEN_W | Length field of the finished request |
| frame_n | output | 1 | Cycle framing, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| devsel_n | input | 1 | Target claim, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop request, active low |
| ad_out | output | DATA_W | Address/data value driven |
| ad_in | input | DATA_W | Address/data value received |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| cbe_out | output | 4 | Command in address phase, byte enables (all on, 0) in data phases |
| cbe_oe | output | 1 | Drive enable for `cbe_out` |

## Verification
The bound checker watches the strobe protocol on every cycle. Initiator-ready is never asserted without framing or an earlier data phase, and the address phase never has initiator-ready asserted. The turnaround cycle has both strobes and the data drive released. It also checks that no request is accepted during data phases, and that the counts go with their codes: zero for retry and master abort, the full length for a normal ending. Other behaviour depends on what the target does, so only the bench scenarios show it. This covers where the master-abort window ends, which code each combination of stop, ready and select produces, the word counts after mid-burst terminations, the write words following their index through wait states, and the read data arriving in order.

// File: rtl/pci_seq_pkg.sv
// Shared types for the PCI initiator sequencer.
package pci_seq_pkg;

    // Bus-side phase of the sequencer
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_TURN = 2'd3
    } seq_state_t;

    // How a transaction ended
    typedef enum logic [2:0] {
        CPL_OK     = 3'd0,
        CPL_RETRY  = 3'd1,
        CPL_DISC   = 3'd2,
        CPL_TABORT = 3'd3,
        CPL_MABORT = 3'd4
    } cpl_code_t;

endpackage

// File: rtl/pci_seq_devsel_win.sv
// Claim-window timer.
// Counts the data-phase clocks that pass without a target claim after the
// address phase, and flags expiry on the WIN-th edge without a claim.
// Assumes start pulses in the address phase and active is high only in
// data phases.
module pci_seq_devsel_win #(
    parameter int WIN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    input  logic devsel_n,
    output logic claimed,
    output logic expire
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] cnt_q;
    logic          seen_q;

    // Track the first claim and count unclaimed data clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (active) begin
            if (!devsel_n) begin
                seen_q <= 1'b1;
            end else if (!seen_q) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // Expiry is raised on the last edge of the window with no claim
    always_comb begin
        expire  = active && !seen_q && devsel_n && (cnt_q == CW'(WIN - 1));
        claimed = seen_q;
    end
endmodule

// File: rtl/pci_seq_beats.sv
// Word counter for one burst.
// Counts the completed data words and flags the data phase of the final
// word. Assumes words_m1 stays stable while the burst runs.
module pci_seq_beats #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    input  logic [LEN_W-1:0] words_m1,
    output logic [LEN_W:0]   count,
    output logic             last,
    output logic             any
);
    logic [LEN_W:0] cnt_q;

    // Count completed words, restarting on every accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + (LEN_W+1)'(1);
        end
    end

    // Final-word flag and nonzero flag
    always_comb begin
        count = cnt_q;
        last  = (cnt_q[LEN_W-1:0] == words_m1);
        any   = (cnt_q != '0);
    end
endmodule

// File: rtl/pci_seq_ctl.sv
// Phase controller and termination decoder.
// Steps idle -> address -> data -> turnaround -> idle, and decides in each
// data clock whether a word moves and whether and how the transaction ends.
// Assumes the target strobes are sampled only in data phases.
module pci_seq_ctl
    import pci_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       devsel_n,
    input  logic       trdy_n,
    input  logic       stop_n,
    input  logic       expire,
    input  logic       claimed,
    input  logic       last,
    input  logic       any_beat,
    output seq_state_t state,
    output logic       accept,
    output logic       beat_inc,
    output cpl_code_t  code
);
    seq_state_t state_q, state_d;
    cpl_code_t  code_q, code_d;
    logic       xfer;

    // Next phase, word strobe and ending code
    always_comb begin
        state_d  = state_q;
        code_d   = code_q;
        beat_inc = 1'b0;
        accept   = 1'b0;
        xfer     = !trdy_n && !devsel_n;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    state_d = ST_ADDR;
                end
            end
            ST_ADDR: state_d = ST_DATA;
            ST_DATA: begin
                if (expire) begin
                    code_d  = CPL_MABORT;
                    state_d = ST_TURN;
                end else if (!stop_n && devsel_n && claimed) begin
                    code_d  = CPL_TABORT;
                    state_d = ST_TURN;
                end else if (!stop_n && !devsel_n) begin
                    state_d  = ST_TURN;
                    beat_inc = xfer;
                    code_d   = (xfer || any_beat) ? CPL_DISC : CPL_RETRY;
                end else if (xfer) begin
                    beat_inc = 1'b1;
                    if (last) begin
                        code_d  = CPL_OK;
                        state_d = ST_TURN;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase and code registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= CPL_OK;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    assign state = state_q;
    assign code  = code_q;
endmodule

// File: rtl/pci_init_seq.sv
// PCI initiator transfer sequencer, top level.
// Holds the accepted request, drives the address/data and command lanes,
// the framing and initiator-ready strobes, captures read words and presents
// the completion report in the turnaround cycle.
// Assumes a granted bus and a requester that supplies wr_data for wr_idx
// combinationally.
module pci_init_seq
    import pci_seq_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int LEN_W      = 4,
    parameter int DEVSEL_WIN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [3:0]        req_cmd,
    input  logic [LEN_W-1:0]  req_len,
    output logic [LEN_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done_valid,
    output logic [2:0]        done_code,
    output logic [LEN_W:0]    done_count,
    output logic [DATA_W-1:0] done_addr,
    output logic [3:0]        done_cmd,
    output logic [LEN_W-1:0]  done_len,
    output logic              frame_n,
    output logic              irdy_n,
    input  logic              devsel_n,
    input  logic              trdy_n,
    input  logic              stop_n,
    output logic [DATA_W-1:0] ad_out,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ad_oe,
    output logic [3:0]        cbe_out,
    output logic              cbe_oe
);
    seq_state_t        state;
    cpl_code_t         code;
    logic              accept, beat_inc, expire, claimed, last, any_beat;
    logic [LEN_W:0]    count;
    logic [DATA_W-1:0] addr_q;
    logic [3:0]        cmd_q;
    logic [LEN_W-1:0]  len_q;
    logic              is_write, in_addr, in_data;

    pci_seq_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .devsel_n (devsel_n),
        .trdy_n   (trdy_n),
        .stop_n   (stop_n),
        .expire   (expire),
        .claimed  (claimed),
        .last     (last),
        .any_beat (any_beat),
        .state    (state),
        .accept   (accept),
        .beat_inc (beat_inc),
        .code     (code)
    );

    pci_seq_devsel_win #(.WIN(DEVSEL_WIN)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (in_addr),
        .active  (in_data),
        .devsel_n(devsel_n),
        .claimed (claimed),
        .expire  (expire)
    );

    pci_seq_beats #(.LEN_W(LEN_W)) u_beats (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .inc     (beat_inc),
        .words_m1(len_q),
        .count   (count),
        .last    (last),
        .any     (any_beat)
    );

    // Hold the request for the whole transaction and for the report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cmd_q  <= '0;
            len_q  <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            cmd_q  <= req_cmd;
            len_q  <= req_len;
        end
    end

    // Capture read words on the edge that completes them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= beat_inc && !is_write;
            if (beat_inc && !is_write) begin
                rd_data <= ad_in;
            end
        end
    end

    // Phase decode and strobe generation
    always_comb begin
        in_addr   = (state == ST_ADDR);
        in_data   = (state == ST_DATA);
        is_write  = cmd_q[0];
        req_ready = (state == ST_IDLE);
        frame_n   = !(in_addr || (in_data && !last));
        irdy_n    = !in_data;
    end

    // Address/data and command lane multiplexing
    always_comb begin
        ad_out  = '0;
        cbe_out = 4'h0;
        ad_oe   = 1'b0;
        cbe_oe  = in_addr || in_data;
        if (in_addr) begin
            ad_out  = addr_q;
            cbe_out = cmd_q;
            ad_oe   = 1'b1;
        end else if (in_data && is_write) begin
            ad_out = wr_data;
            ad_oe  = 1'b1;
        end
    end

    // Completion report, valid in the turnaround cycle
    always_comb begin
        wr_idx     = count[LEN_W-1:0];
        done_valid = (state == ST_TURN);
        done_code  = code;
        done_count = count;
        done_addr  = addr_q;
        done_cmd   = cmd_q;
        done_len   = len_q;
    end
endmodule

// File: rtl/pci_init_seq_chk.sv
// Protocol checker for pci_init_seq, attached by bind.
module pci_init_seq_chk #(
    parameter int LEN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             frame_n,
    input logic             irdy_n,
    input logic             ad_oe,
    input logic             trdy_n,
    input logic             devsel_n,
    input logic             rd_valid,
    input logic             done_valid,
    input logic [2:0]       done_code,
    input logic [LEN_W:0]   done_count,
    input logic [LEN_W-1:0] done_len
);
    logic [LEN_W:0] full_cnt;
    assign full_cnt = {1'b0, done_len} + {{LEN_W{1'b0}}, 1'b1};

    // R2: the address phase starts with initiator-ready released and lanes driven
    a_r2_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n) |-> (irdy_n && ad_oe));

    // R5: initiator-ready only follows framing or an earlier data phase
    a_r5_irdy_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !irdy_n |-> $past(!frame_n || !irdy_n));

    // R4: a read word follows a completed data phase
    a_r4_rd_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!irdy_n && !trdy_n && !devsel_n));

    // R11: turnaround releases everything
    a_r11_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (frame_n && irdy_n && !ad_oe && !req_ready));

    // R11: exactly one report cycle, then idle
    a_r11_single_report: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && req_ready));

    // R12: no acceptance while data phases run
    a_r12_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !irdy_n |-> !req_ready);

    // R6: master abort moves nothing
    a_r6_mabort_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_code == 3'd4) |-> (done_count == '0));

    // R8: retry moves nothing
    a_r8_retry_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_code == 3'd1) |-> (done_count == '0));

    // R10: normal ending moves the full burst
    a_r10_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_code == 3'd0) |-> (done_count == full_cnt));
endmodule

bind pci_init_seq pci_init_seq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .ad_oe     (ad_oe),
    .trdy_n    (trdy_n),
    .devsel_n  (devsel_n),
    .rd_valid  (rd_valid),
    .done_valid(done_valid),
    .done_code (done_code),
    .done_count(done_count),
    .done_len  (done_len)
);

// File: tb/sim_pci_init_seq.sv
`timescale 1ns/100ps
module sim_pci_init_seq;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [DATA_W-1:0] req_addr = '0;
    logic [3:0]        req_cmd = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [LEN_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              done_valid;
    logic [2:0]        done_code;
    logic [LEN_W:0]    done_count;
    logic [DATA_W-1:0] done_addr;
    logic [3:0]        done_cmd;
    logic [LEN_W-1:0]  done_len;
    logic              frame_n, irdy_n;
    logic              devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
    logic [DATA_W-1:0] ad_out;
    logic [DATA_W-1:0] ad_in = '0;
    logic              ad_oe;
    logic [3:0]        cbe_out;
    logic              cbe_oe;

    pci_init_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_cmd(req_cmd), .req_len(req_len),
        .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .done_valid(done_valid), .done_code(done_code), .done_count(done_count),
        .done_addr(done_addr), .done_cmd(done_cmd), .done_len(done_len),
        .frame_n(frame_n), .irdy_n(irdy_n),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
        .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe),
        .cbe_out(cbe_out), .cbe_oe(cbe_oe)
    );

    // Requester write-word source: word n of any burst
    assign wr_data = 32'h5A00_0000 + 32'(wr_idx);

    typedef struct {
        logic [2:0]  code;
        int          cnt;
        logic [31:0] addr;
        logic [3:0]  cmd;
        logic [3:0]  len;
        string       tag;
    } cpl_t;

    cpl_t        cplq[$];
    logic [31:0] rdq[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_word(input logic [31:0] a, input int b);
        return a ^ (32'h1111_0000 + 32'(b));
    endfunction

    // Scoreboard monitor: pops expected completions and read words
    always @(negedge clk) begin
        cpl_t        e;
        logic [31:0] w;
        if (rst_n) begin
            if (done_valid) begin
                if (cplq.size() == 0) begin
                    chk(1'b0, "R11", "unexpected completion", 1, 0);
                end else begin
                    e = cplq.pop_front();
                    chk(done_code == e.code, e.tag, "done_code", done_code, e.code);
                    chk(done_count == e.cnt, e.tag, "done_count", done_count, e.cnt);
                    chk(done_addr == e.addr && done_cmd == e.cmd && done_len == e.len,
                        "R8", "returned request", {done_addr, done_cmd, done_len},
                        {e.addr, e.cmd, e.len});
                end
            end
            if (rd_valid) begin
                if (rdq.size() == 0) begin
                    chk(1'b0, "R4", "unexpected read word", rd_data, 0);
                end else begin
                    w = rdq.pop_front();
                    chk(rd_data == w, "R4", "read word", rd_data, w);
                end
            end
        end
    end

    // Driver: issues one request and plays the target for it.
    // lat: data clocks before the claim (>=5 never claims); waits: wait
    // clocks before each word; sb: word index where stop is given;
    // sm: 0 stop with ready, 1 stop without ready, 2 stop with claim dropped.
    task automatic run_txn(input logic [31:0] a, input logic [3:0] cmd,
                           input logic [3:0] len, input int lat, input int waits,
                           input int sb, input int sm, input bit spam);
        int   words;
        int   b;
        int   w;
        int   c;
        bit   fin;
        bit   dev;
        cpl_t e;
        words = int'(len) + 1;
        b = 0; w = 0; c = 0; fin = 1'b0;
        e.addr = a; e.cmd = cmd; e.len = len;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready before request", req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_cmd = cmd; req_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        chk(frame_n == 1'b0 && irdy_n == 1'b1 && ad_oe == 1'b1, "R2",
            "address phase strobes", {frame_n, irdy_n, ad_oe}, 3'b011);
        chk(ad_out == a && cbe_out == cmd, "R2", "address and command",
            {ad_out, cbe_out}, {a, cmd});
        @(negedge clk);
        while (!fin) begin
            chk(irdy_n == 1'b0, "R3", "irdy in data phase", irdy_n, 0);
            chk(frame_n == (b == words - 1), "R5", "frame in data phase",
                frame_n, (b == words - 1));
            if (cmd[0]) begin
                chk(ad_oe == 1'b1 && ad_out == 32'h5A00_0000 + 32'(b) && wr_idx == b[3:0],
                    "R3", "write word", {ad_oe, ad_out}, {1'b1, 32'h5A00_0000 + 32'(b)});
            end else begin
                chk(ad_oe == 1'b0, "R3", "read drive off", ad_oe, 0);
            end
            if (spam) begin
                req_valid = 1'b1; req_addr = ~a; req_cmd = ~cmd; req_len = ~len;
                chk(req_ready == 1'b0, "R12", "ready while busy", req_ready, 0);
            end
            devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
            ad_in = rd_word(a, b);
            dev = (c >= lat);
            if (!dev) begin
                if (c == 4) begin
                    e.code = 3'd4; e.cnt = 0; e.tag = "R6"; fin = 1'b1;
                end
            end else if (b == sb && sm == 2) begin
                stop_n = 1'b0;
                e.code = 3'd3; e.cnt = b; e.tag = "R9"; fin = 1'b1;
            end else begin
                devsel_n = 1'b0;
                if (w >= waits) begin
                    if (b == sb && sm == 0) begin
                        trdy_n = 1'b0; stop_n = 1'b0;
                        if (!cmd[0]) rdq.push_back(rd_word(a, b));
                        e.code = 3'd2; e.cnt = b + 1; e.tag = "R7"; fin = 1'b1;
                    end else if (b == sb && sm == 1) begin
                        stop_n = 1'b0;
                        e.code = (b == 0) ? 3'd1 : 3'd2; e.cnt = b;
                        e.tag = (b == 0) ? "R8" : "R8 disconnect"; fin = 1'b1;
                    end else begin
                        trdy_n = 1'b0;
                        if (!cmd[0]) rdq.push_back(rd_word(a, b));
                        b++; w = 0;
                        if (b == words) begin
                            e.code = 3'd0; e.cnt = words; e.tag = "R10"; fin = 1'b1;
                        end
                    end
                end else begin
                    w++;
                end
            end
            if (fin) cplq.push_back(e);
            @(negedge clk);
            c++;
        end
        req_valid = 1'b0;
        devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
        chk(frame_n == 1'b1 && irdy_n == 1'b1 && ad_oe == 1'b0 && done_valid == 1'b1,
            "R11", "turnaround cycle", {frame_n, irdy_n, ad_oe, done_valid}, 4'b1101);
        @(negedge clk);
        chk(req_ready == 1'b1 && done_valid == 1'b0, "R11", "idle after turnaround",
            {req_ready, done_valid}, 2'b10);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R11 watchdog: actual hung expected done");
            finished = 1'b1;
            summary();
            $finish;
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        chk(frame_n && irdy_n && !ad_oe && !done_valid && req_ready, "R1",
            "state in reset", {frame_n, irdy_n, ad_oe, done_valid, req_ready}, 5'b11001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(frame_n && irdy_n && !ad_oe && !done_valid && req_ready, "R1",
            "state after reset", {frame_n, irdy_n, ad_oe, done_valid, req_ready}, 5'b11001);
        run_txn(32'h1000_0040, 4'h6, 4'd3, 0, 0, -1, 0, 1'b0);  // R10 read burst
        run_txn(32'h2000_0080, 4'h7, 4'd2, 2, 1, -1, 0, 1'b0);  // R4 waits, write
        run_txn(32'h3000_0000, 4'h6, 4'd0, 1, 0, -1, 0, 1'b0);  // R5 single word
        run_txn(32'h4000_0100, 4'h7, 4'd3, 9, 0, -1, 0, 1'b0);  // R6 no claim
        run_txn(32'h4800_0100, 4'h6, 4'd1, 4, 0, -1, 0, 1'b0);  // R6 claim on last edge
        run_txn(32'h5000_0200, 4'h6, 4'd3, 0, 1, 0, 1, 1'b1);   // R8 retry, R12
        run_txn(32'h6000_0300, 4'h7, 4'd5, 1, 0, 2, 0, 1'b0);   // R7 disconnect with data
        run_txn(32'h7000_0400, 4'h6, 4'd4, 0, 1, 2, 1, 1'b0);   // R8 disconnect without data
        run_txn(32'h8000_0500, 4'h7, 4'd2, 0, 0, 1, 2, 1'b0);   // R9 target abort
        run_txn(32'h9000_0600, 4'h7, 4'd15, 0, 0, -1, 0, 1'b1); // R10 longest burst, R12
        repeat (3) @(negedge clk);
        chk(cplq.size() == 0 && rdq.size() == 0, "R11", "all results seen",
            cplq.size() + rdq.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end
endmodule